// File: doc/BRIEF.md
# Three-Bus Fetch-and-Add Datapath Controller

This block is a small processor datapath with three internal buses and a step sequencer that runs it. The register file drives two buses, A and B, from its two read ports. Its single write port takes bus C, which the ALU output drives. A mux on the ALU's first operand picks either bus A or the constant 4. The ALU either adds its two operands or passes bus B straight through. The program counter has its own +4 incrementer, so advancing it never uses the ALU.

The sequencer runs one instruction in four steps. In the fetch step the PC crosses the ALU in pass mode into the memory address register, a read request starts, and the incrementer advances the PC. The wait step stalls until memory reports that the read has completed. The load step carries the returned word from the data register over bus B into the instruction register. The execute step reads two source registers, adds them, writes the sum into the destination register and flags end of instruction. The sequencer then returns to fetch.

Top module: `tbus_core`

## Requirements
- R1: While reset is low and in the first cycle after its release, the step output is fetch (code 0), `pc_o` is 0, and `mem_rd`, `wr_en` and `end_o` are low. Register k of the file holds the value k after reset.
- R2: In the cycle after a fetch step, the step is wait (code 1), `mem_rd` is high, and `mem_addr` shows the PC value that fetch began with. `pc_o` has advanced by 4 modulo 2^32.
- R3: While the step is wait and `mem_done` is low, the step stays wait, `mem_rd` stays high, `mem_addr` and `pc_o` hold, and no register write happens.
- R4: A wait cycle with `mem_done` high captures `mem_rdata` and moves to the load step (code 2). In the load step `mem_rd` and `wr_en` are low, and the captured word becomes the instruction.
- R5: In the execute step (code 3), `wr_en` and `end_o` are high and `wr_data` = reg[IR[5:3]] + reg[IR[8:6]] modulo 2^32. The value goes to register `wr_idx` = IR[2:0]. Instruction bits 31:9 have no effect.
- R6: When the destination is also a source, the execute step adds the values held before the write. The new value is what the next instruction reads.
- R7: The cycle after `end_o` is a fetch step. An instruction whose read completes after L stalled wait cycles takes 4 + L cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Memory address register contents |
| mem_rd | output | 1 | Read request, high from fetch until completion |
| mem_rdata | input | 32 | Read data from memory |
| mem_done | input | 1 | Memory read completed |
| pc_o | output | 32 | Program counter |
| step_o | output | 2 | Current step: 0 fetch, 1 wait, 2 load, 3 execute |
| wr_en | output | 1 | Register-file write strobe (bus C) |
| wr_idx | output | 3 | Destination register index |
| wr_data | output | 32 | Bus C value being written |
| end_o | output | 1 | End of instruction |

## Verification
A wrong step in the sequencer shows at the ports within one cycle. It appears as `mem_rd` at the wrong time, a missing or early `wr_en`, or a PC that moves during a stall. A corrupted register-file entry stays hidden until an instruction reads it. The bench therefore keeps a shadow register model and chains each result into later sources, so a bad entry appears on `wr_data` at that later execute step. Destinations that are also sources, and a sum that doubles until it wraps, expose read-during-write ordering and carry truncation on the next dependent instruction.

// File: rtl/tbus_pkg.sv
package tbus_pkg;
  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_WAIT  = 2'd1,
    ST_LDIR  = 2'd2,
    ST_EXEC  = 2'd3
  } step_e;

  typedef enum logic [1:0] {
    BSRC_PC  = 2'd0,
    BSRC_MDR = 2'd1,
    BSRC_RF  = 2'd2
  } bsrc_e;

  typedef struct packed {
    logic  mar_ld;
    logic  rd_start;
    logic  pc_inc;
    logic  ir_ld;
    logic  rf_we;
    logic  sel_const4;
    logic  alu_add;
    bsrc_e bsrc;
    logic  end_s;
  } ctrl_t;
endpackage

// File: rtl/tbus_seq.sv
module tbus_seq
  import tbus_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mem_done,
  output step_e step,
  output ctrl_t ctrl
);
  step_e step_d;

  always_comb begin
    step_d = step;
    unique case (step)
      ST_FETCH: step_d = ST_WAIT;
      ST_WAIT:  if (mem_done) step_d = ST_LDIR;
      ST_LDIR:  step_d = ST_EXEC;
      ST_EXEC:  step_d = ST_FETCH;
      default:  step_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step <= ST_FETCH;
    else        step <= step_d;
  end

  always_comb begin
    ctrl = '0;
    ctrl.bsrc = BSRC_RF;
    unique case (step)
      ST_FETCH: begin
        ctrl.bsrc     = BSRC_PC;
        ctrl.mar_ld   = 1'b1;
        ctrl.rd_start = 1'b1;
        ctrl.pc_inc   = 1'b1;
      end
      ST_LDIR: begin
        ctrl.bsrc  = BSRC_MDR;
        ctrl.ir_ld = 1'b1;
      end
      ST_EXEC: begin
        ctrl.bsrc    = BSRC_RF;
        ctrl.alu_add = 1'b1;
        ctrl.rf_we   = 1'b1;
        ctrl.end_s   = 1'b1;
      end
      default: ctrl.bsrc = BSRC_RF;
    endcase
  end
endmodule

// File: rtl/tbus_regfile.sv
module tbus_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd
);
  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hit;
    assign hit = we && (wa == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[i] <= DW'(i);
      else if (hit) regs[i] <= wd;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];
endmodule

// File: rtl/tbus_alu.sv
module tbus_alu #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] bus_a,
  input  logic [DW-1:0] bus_b,
  input  logic          sel_const4,
  input  logic          add,
  output logic [DW-1:0] y
);
  localparam logic [DW-1:0] FOUR = DW'(4);
  logic [DW-1:0] opa;

  assign opa = sel_const4 ? FOUR : bus_a;
  assign y   = add ? (opa + bus_b) : bus_b;
endmodule

// File: rtl/tbus_core.sv
module tbus_core
  import tbus_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_done,
  output logic [DW-1:0] pc_o,
  output logic [1:0]    step_o,
  output logic          wr_en,
  output logic [AW-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic          end_o
);
  localparam logic [DW-1:0] PC_STEP = DW'(4);

  step_e         step;
  ctrl_t         ctrl;
  logic [DW-1:0] pc_q, mar_q, mdr_q, ir_q;
  logic          rd_q, rd_d, mdr_en;
  logic [DW-1:0] bus_a, bus_b, bus_c, rf_b;
  logic [AW-1:0] fld_a, fld_b, fld_d;

  tbus_seq u_seq (
    .clk(clk), .rst_n(rst_n), .mem_done(mem_done), .step(step), .ctrl(ctrl)
  );

  assign fld_d = ir_q[AW-1:0];
  assign fld_a = ir_q[2*AW-1:AW];
  assign fld_b = ir_q[3*AW-1:2*AW];

  tbus_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_a(fld_a), .ra_b(fld_b), .rd_a(bus_a), .rd_b(rf_b),
    .we(ctrl.rf_we), .wa(fld_d), .wd(bus_c)
  );

  always_comb begin
    unique case (ctrl.bsrc)
      BSRC_PC:  bus_b = pc_q;
      BSRC_MDR: bus_b = mdr_q;
      default:  bus_b = rf_b;
    endcase
  end

  tbus_alu #(.DW(DW)) u_alu (
    .bus_a(bus_a), .bus_b(bus_b), .sel_const4(ctrl.sel_const4),
    .add(ctrl.alu_add), .y(bus_c)
  );

  assign mdr_en = (step == ST_WAIT) && mem_done;

  always_comb begin
    rd_d = rd_q;
    if (ctrl.rd_start) rd_d = 1'b1;
    else if (mdr_en)   rd_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      rd_q  <= 1'b0;
    end else begin
      rd_q <= rd_d;
      if (ctrl.pc_inc) pc_q  <= pc_q + PC_STEP;
      if (ctrl.mar_ld) mar_q <= bus_c;
      if (mdr_en)      mdr_q <= mem_rdata;
      if (ctrl.ir_ld)  ir_q  <= bus_c;
    end
  end

  assign mem_addr = mar_q;
  assign mem_rd   = rd_q;
  assign pc_o     = pc_q;
  assign step_o   = step;
  assign wr_en    = ctrl.rf_we;
  assign wr_idx   = fld_d;
  assign wr_data  = bus_c;
  assign end_o    = ctrl.end_s;
endmodule

// File: rtl/tbus_core_chk.sv
module tbus_core_chk #(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_done,
  input logic [DW-1:0] pc_o,
  input logic [1:0]    step_o,
  input logic          wr_en,
  input logic          end_o
);
  p_pc_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o == 2'd0) |=> (pc_o == $past(pc_o) + DW'(4)) && mem_rd);

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o == 2'd1 && !mem_done) |=> (step_o == 2'd1) && $stable(pc_o) && $stable(mem_addr));

  p_no_write_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !wr_en);

  p_done_to_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o == 2'd1 && mem_done) |=> (step_o == 2'd2) && !mem_rd);

  p_end_then_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> (step_o == 2'd0) && !end_o && !wr_en);
endmodule

bind tbus_core tbus_core_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
  .mem_done(mem_done), .pc_o(pc_o), .step_o(step_o), .wr_en(wr_en),
  .end_o(end_o)
);

// File: tb/tbus_core_bench.sv
`timescale 1ns/1ps
module tbus_core_bench;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam int N_VEC = 10;
  // each entry: {latency[3:0], b[2:0], a[2:0], d[2:0]}
  localparam logic [12:0] VEC [N_VEC] = '{
    {4'd0, 3'd2, 3'd1, 3'd3},
    {4'd2, 3'd3, 3'd3, 3'd3},
    {4'd1, 3'd4, 3'd3, 3'd0},
    {4'd3, 3'd7, 3'd0, 3'd0},
    {4'd0, 3'd5, 3'd6, 3'd7},
    {4'd5, 3'd0, 3'd7, 3'd1},
    {4'd0, 3'd1, 3'd1, 3'd2},
    {4'd1, 3'd2, 3'd5, 3'd5},
    {4'd2, 3'd4, 3'd4, 3'd6},
    {4'd0, 3'd6, 3'd2, 3'd4}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] mem_addr;
  logic          mem_rd;
  logic [DW-1:0] mem_rdata;
  logic          mem_done;
  logic [DW-1:0] pc_o;
  logic [1:0]    step_o;
  logic          wr_en;
  logic [AW-1:0] wr_idx;
  logic [DW-1:0] wr_data;
  logic          end_o;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [8];
  logic [DW-1:0] exp_pc;

  always #4 clk = ~clk;

  tbus_core u_tbus_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_done(mem_done), .pc_o(pc_o), .step_o(step_o),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .end_o(end_o)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // Runs one instruction; called at a negedge while in fetch.
  task automatic run_instr(input logic [2:0] a, input logic [2:0] b,
                           input logic [2:0] d, input int lat,
                           input logic [22:0] junk);
    logic [DW-1:0] sum;
    logic [DW-1:0] ir;
    ir  = {junk, b, a, d};
    sum = model[a] + model[b];
    chk(step_o == 2'd0 && !mem_rd, "R7 fetch", {30'd0, step_o}, 0);
    @(negedge clk);
    chk(step_o == 2'd1 && mem_rd, "R2 wait", {30'd0, step_o}, 1);
    chk(mem_addr == exp_pc, "R2 addr", mem_addr, exp_pc);
    chk(pc_o == exp_pc + 4, "R2 pc", pc_o, exp_pc + 4);
    for (int i = 0; i < lat; i++) begin
      mem_rdata = 32'hDEAD0000 | i;
      @(negedge clk);
      chk(step_o == 2'd1 && mem_rd && !wr_en, "R3 stall", {30'd0, step_o}, 1);
      chk(mem_addr == exp_pc && pc_o == exp_pc + 4, "R3 hold", pc_o, exp_pc + 4);
    end
    mem_done  = 1'b1;
    mem_rdata = ir;
    @(negedge clk);
    mem_done  = 1'b0;
    mem_rdata = 32'h5A5A5A5A;
    chk(step_o == 2'd2 && !mem_rd && !wr_en, "R4 load", {30'd0, step_o}, 2);
    @(negedge clk);
    chk(step_o == 2'd3 && wr_en && end_o, "R5 exec", {30'd0, step_o}, 3);
    chk(wr_idx == d, "R5 dest", {29'd0, wr_idx}, {29'd0, d});
    chk(wr_data == sum, (a == d || b == d) ? "R6 old operand" : "R5 sum",
        wr_data, sum);
    model[d] = sum;
    exp_pc   = exp_pc + 4;
    @(negedge clk);
    chk(step_o == 2'd0 && !end_o && !wr_en, "R7 back to fetch",
        {30'd0, step_o}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t0;
    int t1;
    for (int k = 0; k < 8; k++) model[k] = DW'(k);
    exp_pc    = '0;
    mem_done  = 1'b0;
    mem_rdata = '0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    chk(step_o == 2'd0 && pc_o == 0 && !mem_rd && !wr_en && !end_o,
        "R1 reset", pc_o, 0);
    rst_n = 1'b1;
    chk(step_o == 2'd0 && pc_o == 0 && !mem_rd, "R1 after release", pc_o, 0);

    for (int v = 0; v < N_VEC; v++)
      run_instr(VEC[v][5:3], VEC[v][8:6], VEC[v][2:0], int'(VEC[v][12:9]),
                23'h5A5A5A ^ 23'(v * 97));

    // R6: destination equal to both sources, doubling until wrap (R5 modulo).
    for (int n = 0; n < 34; n++)
      run_instr(3'd3, 3'd3, 3'd3, n % 2, 23'h7FFFFF);

    // R6: new value visible to the following instruction.
    run_instr(3'd2, 3'd2, 3'd2, 0, 23'd0);
    run_instr(3'd2, 3'd0, 3'd1, 0, 23'd1);

    // R7: cycle count for latency 3 equals 4 + 3.
    t0 = checks;
    begin
      int cyc;
      cyc = 0;
      fork
        run_instr(3'd4, 3'd5, 3'd6, 3, 23'd9);
        begin
          @(negedge clk);
          while (!end_o) begin
            @(negedge clk);
            cyc++;
          end
        end
      join
      t1 = cyc + 2;
      chk(t1 == 7, "R7 cycle count", DW'(t1), 7);
    end

    // R1: reset mid-instruction restores register file and PC.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) model[k] = DW'(k);
    exp_pc = '0;
    chk(pc_o == 0 && step_o == 2'd0, "R1 re-reset", pc_o, 0);
    run_instr(3'd6, 3'd7, 3'd5, 0, 23'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule